// File: doc/BRIEF.md
# Software Write-Protect Sequencer

This block sits between the bus-side write qualifier and the page-write engine of a byte-wide EEPROM array. The array is divided into several large address blocks. Each qualified write event carries a block index, a 17-bit in-block address and one data byte. The sequencer watches these events for fixed multi-write command sequences. Each block has a protect flag, and the sequences either turn that flag on or turn it off. For every write, the sequencer reports one of three outcomes. A write may be passed to the page engine. A write may be dropped, which raises a dummy-busy request so that the engine still runs a full write period without storing data. A write may be absorbed as a command byte.

The page engine signals the end of each write period with a one-cycle `period_end` pulse. Flag changes requested by a completed sequence take effect at that boundary, and the sequence matcher is cleared there as well. The protect flags stand in for non-volatile storage. They power up cleared, and the synchronous reset never touches them.

Top module: `swp_sequencer`

## Requirements
- R1: The protect flags power up all cleared, and `rst` leaves them unchanged. `rst` forces `dec_valid` and `dummy_busy` low and discards any partly matched sequence.
- R2: Each write accepted on `wr_valid` produces exactly one decision, with `dec_valid` high in the following cycle. The `dec_kind` codes are 0 for pass, 1 for drop and 2 for a command byte.
- R3: A write that is not a command byte, sent to a block whose flag is clear, is passed. It is never dropped.
- R4: The enable sequence is three writes to one block: 0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. Each of the three writes is reported as a command byte. The block's flag is set at the next `period_end`, even if no data write follows, and `protect` shows the new value one cycle after that pulse.
- R5: After a complete enable (unlock) or disable sequence, the later writes to the same block in the same write period are passed, even while the block's flag is set.
- R6: A non-command write to a protected block that has not been unlocked in the current period is dropped. `dummy_busy` pulses together with that decision.
- R7: The disable sequence is six writes, each reported as a command byte: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. The block's flag is cleared at the next `period_end`.
- R8: A write that does not continue a partly matched sequence resets the matcher. That write is then judged as an ordinary data write under its block's current flag.
- R9: `period_end` clears the matcher, so a sequence cannot span two write periods.
- R10: Every block has its own flag. A write to a different block in the middle of a sequence breaks that sequence.
- R11: `protect` changes only in the cycle after a `period_end` pulse, and only in the block of the sequence that completed.
- R12: When `period_end` and a write arrive in the same cycle, the write is judged against the state after the boundary: the matcher is idle and any pending flag change has been applied.
- R13: `dec_valid` stays low in any cycle that follows one with no write. `dummy_busy` is high only together with a drop decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (flags excluded) |
| wr_valid | input | 1 | One qualified write event this cycle |
| wr_blk | input | BLK_W | Block index of the write |
| wr_addr | input | 17 | In-block byte address |
| wr_data | input | 8 | Write data byte |
| period_end | input | 1 | Pulse marking the end of a write period |
| dec_valid | output | 1 | Decision for the previous cycle's write |
| dec_kind | output | 2 | 0 pass, 1 drop, 2 command byte |
| dummy_busy | output | 1 | Request a data-less write period |
| protect | output | NUM_BLK | Current protect flag per block |

## Verification
The hardest situation to reach is a write period boundary that lands in the same cycle as a write while a flag change is still pending. The write must then see the freshly applied flag and a cleared matcher. The stimulus completes an enable sequence on a protected block, then raises `period_end` and a data write to that block together, and expects a drop. The other hard cases are sequences broken mid-way, either by a wrong byte or by a write to another block. These are driven from vector rows that interleave partial prefixes with ordinary data. A reset is also applied while a prefix is half matched, to confirm that the flags survive the reset and the prefix does not.

// File: rtl/swp_pkg.sv
package swp_pkg;

    localparam int ADDR_W = 17;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] CMD_ADDR_A = 17'h05555;
    localparam logic [ADDR_W-1:0] CMD_ADDR_B = 17'h02AAA;

    localparam logic [DATA_W-1:0] BYTE_AA  = 8'hAA;
    localparam logic [DATA_W-1:0] BYTE_55  = 8'h55;
    localparam logic [DATA_W-1:0] BYTE_ON  = 8'hA0;
    localparam logic [DATA_W-1:0] BYTE_ESC = 8'h80;
    localparam logic [DATA_W-1:0] BYTE_OFF = 8'h20;

    typedef enum logic [2:0] {
        M_IDLE, M_P1, M_P2, M_D3, M_D4, M_D5, M_OPEN
    } mstate_e;

    typedef enum logic [1:0] {
        PEND_NONE, PEND_SET, PEND_CLR
    } pend_e;

    localparam logic [1:0] KIND_PASS = 2'd0;
    localparam logic [1:0] KIND_DROP = 2'd1;
    localparam logic [1:0] KIND_CMD  = 2'd2;

    typedef struct packed {
        mstate_e nxt;
        logic    hit;
        pend_e   pend;
    } step_t;

    function automatic step_t seq_step(mstate_e s, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
        step_t r;
        r.nxt  = s;
        r.hit  = 1'b0;
        r.pend = PEND_NONE;
        case (s)
            M_IDLE: if (a == CMD_ADDR_A && d == BYTE_AA) begin r.nxt = M_P1; r.hit = 1'b1; end
            M_P1:   if (a == CMD_ADDR_B && d == BYTE_55) begin r.nxt = M_P2; r.hit = 1'b1; end
            M_P2: begin
                if (a == CMD_ADDR_A && d == BYTE_ON) begin
                    r.nxt = M_OPEN; r.hit = 1'b1; r.pend = PEND_SET;
                end else if (a == CMD_ADDR_A && d == BYTE_ESC) begin
                    r.nxt = M_D3; r.hit = 1'b1;
                end
            end
            M_D3:   if (a == CMD_ADDR_A && d == BYTE_AA) begin r.nxt = M_D4; r.hit = 1'b1; end
            M_D4:   if (a == CMD_ADDR_B && d == BYTE_55) begin r.nxt = M_D5; r.hit = 1'b1; end
            M_D5: begin
                if (a == CMD_ADDR_A && d == BYTE_OFF) begin
                    r.nxt = M_OPEN; r.hit = 1'b1; r.pend = PEND_CLR;
                end
            end
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/swp_matcher.sv
module swp_matcher
    import swp_pkg::*;
#(
    parameter int BLK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [BLK_W-1:0]  wr_blk,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              period_end,
    output logic              cmd_hit,
    output logic              open_hit,
    output pend_e             pend_o,
    output logic [BLK_W-1:0]  seq_blk_o
);

    mstate_e           st_q, st_eff, st_n;
    pend_e             pend_q, pend_eff, pend_n;
    logic [BLK_W-1:0]  blk_q, blk_n;
    logic              same_blk;
    step_t             r;

    assign st_eff   = period_end ? M_IDLE : st_q;
    assign pend_eff = period_end ? PEND_NONE : pend_q;
    assign same_blk = (st_eff == M_IDLE) || (wr_blk == blk_q);
    assign r        = seq_step(st_eff, wr_addr, wr_data);

    assign cmd_hit  = wr_valid && same_blk && r.hit;
    assign open_hit = wr_valid && (st_eff == M_OPEN) && (wr_blk == blk_q);

    always_comb begin
        st_n   = st_eff;
        pend_n = pend_eff;
        blk_n  = blk_q;
        if (wr_valid) begin
            if (cmd_hit) begin
                st_n  = r.nxt;
                blk_n = wr_blk;
                if (r.pend != PEND_NONE) pend_n = r.pend;
            end else if (st_eff != M_OPEN) begin
                st_n = M_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= M_IDLE;
            pend_q <= PEND_NONE;
            blk_q  <= '0;
        end else begin
            st_q   <= st_n;
            pend_q <= pend_n;
            blk_q  <= blk_n;
        end
    end

    assign pend_o    = pend_q;
    assign seq_blk_o = blk_q;

endmodule

// File: rtl/swp_flags.sv
module swp_flags
    import swp_pkg::*;
#(
    parameter int NUM_BLK = 4,
    parameter int BLK_W   = 2
) (
    input  logic               clk,
    input  logic               period_end,
    input  pend_e              pend,
    input  logic [BLK_W-1:0]   seq_blk,
    output logic [NUM_BLK-1:0] prot_q,
    output logic [NUM_BLK-1:0] prot_eff
);

    logic [NUM_BLK-1:0] flag_r = '0;
    logic [NUM_BLK-1:0] prot_app;

    always_comb begin
        prot_app = flag_r;
        if (pend == PEND_SET)      prot_app[seq_blk] = 1'b1;
        else if (pend == PEND_CLR) prot_app[seq_blk] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (period_end) flag_r <= prot_app;
    end

    assign prot_q   = flag_r;
    assign prot_eff = period_end ? prot_app : flag_r;

endmodule

// File: rtl/swp_decide.sv
module swp_decide
    import swp_pkg::*;
#(
    parameter int NUM_BLK = 4,
    parameter int BLK_W   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_valid,
    input  logic [BLK_W-1:0]   wr_blk,
    input  logic               cmd_hit,
    input  logic               open_hit,
    input  logic [NUM_BLK-1:0] prot_eff,
    output logic               dec_valid,
    output logic [1:0]         dec_kind,
    output logic               dummy_busy
);

    logic [1:0] kind_n;

    always_comb begin
        if (cmd_hit)               kind_n = KIND_CMD;
        else if (open_hit)         kind_n = KIND_PASS;
        else if (prot_eff[wr_blk]) kind_n = KIND_DROP;
        else                       kind_n = KIND_PASS;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid  <= 1'b0;
            dec_kind   <= KIND_PASS;
            dummy_busy <= 1'b0;
        end else begin
            dec_valid  <= wr_valid;
            dec_kind   <= wr_valid ? kind_n : KIND_PASS;
            dummy_busy <= wr_valid && (kind_n == KIND_DROP);
        end
    end

endmodule

// File: rtl/swp_sequencer.sv
module swp_sequencer
    import swp_pkg::*;
#(
    parameter int  NUM_BLK = 4,
    localparam int BLK_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_valid,
    input  logic [BLK_W-1:0]   wr_blk,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               period_end,
    output logic               dec_valid,
    output logic [1:0]         dec_kind,
    output logic               dummy_busy,
    output logic [NUM_BLK-1:0] protect
);

    logic               cmd_hit, open_hit;
    pend_e              pend;
    logic [BLK_W-1:0]   seq_blk;
    logic [NUM_BLK-1:0] prot_eff;

    swp_matcher #(.BLK_W(BLK_W)) u_match (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_blk(wr_blk),
        .wr_addr(wr_addr), .wr_data(wr_data), .period_end(period_end),
        .cmd_hit(cmd_hit), .open_hit(open_hit), .pend_o(pend), .seq_blk_o(seq_blk)
    );

    swp_flags #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W)) u_flags (
        .clk(clk), .period_end(period_end), .pend(pend), .seq_blk(seq_blk),
        .prot_q(protect), .prot_eff(prot_eff)
    );

    swp_decide #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W)) u_dec (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_blk(wr_blk),
        .cmd_hit(cmd_hit), .open_hit(open_hit), .prot_eff(prot_eff),
        .dec_valid(dec_valid), .dec_kind(dec_kind), .dummy_busy(dummy_busy)
    );

endmodule

// File: rtl/swp_sequencer_chk.sv
module swp_sequencer_chk #(
    parameter int NUM_BLK = 4,
    parameter int BLK_W   = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_valid,
    input logic [BLK_W-1:0]   wr_blk,
    input logic               period_end,
    input logic               dec_valid,
    input logic [1:0]         dec_kind,
    input logic               dummy_busy,
    input logic [NUM_BLK-1:0] protect
);

    assert_decision_follows_write_R2: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> dec_valid);

    assert_no_spurious_decision_R13: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> (!dec_valid && !dummy_busy));

    assert_unprotected_never_dropped_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !period_end && !protect[wr_blk]) |=> (dec_kind != 2'd1));

    assert_flags_static_between_periods_R11: assert property (@(posedge clk) disable iff (rst)
        !period_end |=> $stable(protect));

    assert_one_block_per_boundary_R10: assert property (@(posedge clk) disable iff (rst)
        period_end |=> ($countones(protect ^ $past(protect)) <= 1));

endmodule

bind swp_sequencer swp_sequencer_chk #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W)) u_chk (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_blk(wr_blk),
    .period_end(period_end), .dec_valid(dec_valid), .dec_kind(dec_kind),
    .dummy_busy(dummy_busy), .protect(protect)
);

// File: tb/swp_sequencer_test.sv
module swp_sequencer_test;

    localparam logic [16:0] A5 = 17'h05555;
    localparam logic [16:0] A2 = 17'h02AAA;
    localparam logic [1:0]  KP = 2'd0, KD = 2'd1, KC = 2'd2, KN = 2'd3;

    typedef struct packed {
        logic        wv;
        logic        pe;
        logic [1:0]  blk;
        logic [16:0] addr;
        logic [7:0]  data;
        logic [1:0]  ek;
        logic [3:0]  ep;
        logic [3:0]  req;
    } vec_t;

    function automatic vec_t mk(logic wv, logic pe, logic [1:0] blk, logic [16:0] addr,
                                logic [7:0] data, logic [1:0] ek, logic [3:0] ep, logic [3:0] req);
        vec_t v;
        v.wv = wv; v.pe = pe; v.blk = blk; v.addr = addr; v.data = data;
        v.ek = ek; v.ep = ep; v.req = req;
        return v;
    endfunction

    localparam int NV = 39;
    localparam vec_t VEC [NV] = '{
        mk(1,0,0,17'h00100,8'h11,KP,4'b0000,3),   // R3 plain write, unprotected
        mk(1,0,0,A5,8'hAA,KC,4'b0000,4),          // R4 enable step 1
        mk(1,0,0,A2,8'h55,KC,4'b0000,4),          // R4 enable step 2
        mk(1,0,0,A5,8'hA0,KC,4'b0000,4),          // R4 enable step 3
        mk(1,0,0,17'h00200,8'h07,KP,4'b0000,5),   // R5 data after enable
        mk(0,1,0,17'h0,8'h0,KN,4'b0001,4),        // R4 flag set at boundary
        mk(1,0,0,17'h00300,8'h01,KD,4'b0001,6),   // R6 no prefix -> drop
        mk(1,0,1,17'h00300,8'h01,KP,4'b0001,10),  // R10 other block free
        mk(1,0,0,A5,8'hAA,KC,4'b0001,5),          // R5 unlock
        mk(1,0,0,A2,8'h55,KC,4'b0001,5),
        mk(1,0,0,A5,8'hA0,KC,4'b0001,5),
        mk(1,0,0,17'h00300,8'h44,KP,4'b0001,5),   // R5 unlocked data passes
        mk(0,1,0,17'h0,8'h0,KN,4'b0001,11),       // R11 stays set
        mk(1,0,0,A5,8'hAA,KC,4'b0001,8),          // R8 partial prefix
        mk(1,0,0,A2,8'h12,KD,4'b0001,8),          // R8 wrong byte -> ordinary drop
        mk(1,0,0,A2,8'h55,KD,4'b0001,8),          // R8 matcher was reset
        mk(0,1,0,17'h0,8'h0,KN,4'b0001,11),
        mk(1,0,0,A5,8'hAA,KC,4'b0001,7),          // R7 disable sequence
        mk(1,0,0,A2,8'h55,KC,4'b0001,7),
        mk(1,0,0,A5,8'h80,KC,4'b0001,7),
        mk(1,0,0,A5,8'hAA,KC,4'b0001,7),
        mk(1,0,0,A2,8'h55,KC,4'b0001,7),
        mk(1,0,0,A5,8'h20,KC,4'b0001,11),         // R11 no change before boundary
        mk(0,1,0,17'h0,8'h0,KN,4'b0000,7),        // R7 cleared at boundary
        mk(1,0,0,17'h00400,8'h99,KP,4'b0000,3),
        mk(1,0,0,A5,8'hAA,KC,4'b0000,9),          // R9 prefix before boundary
        mk(0,1,0,17'h0,8'h0,KN,4'b0000,9),
        mk(1,0,0,A2,8'h55,KP,4'b0000,9),          // R9 continuation lost
        mk(1,0,2,A5,8'hAA,KC,4'b0000,4),          // R4 enable with no data
        mk(1,0,2,A2,8'h55,KC,4'b0000,4),
        mk(1,0,2,A5,8'hA0,KC,4'b0000,4),
        mk(0,1,0,17'h0,8'h0,KN,4'b0100,4),
        mk(1,0,0,A5,8'hAA,KC,4'b0100,10),         // R10 prefix on block 0
        mk(1,0,1,A2,8'h55,KP,4'b0100,10),         // R10 block switch breaks
        mk(0,1,0,17'h0,8'h0,KN,4'b0100,10),
        mk(1,0,2,A5,8'hAA,KC,4'b0100,12),         // R12 unlock block 2
        mk(1,0,2,A2,8'h55,KC,4'b0100,12),
        mk(1,0,2,A5,8'hA0,KC,4'b0100,12),
        mk(1,1,2,17'h00010,8'h33,KD,4'b0100,12)   // R12 boundary + write -> drop
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [1:0]  wr_blk = '0;
    logic [16:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        period_end = 1'b0;
    logic        dec_valid;
    logic [1:0]  dec_kind;
    logic        dummy_busy;
    logic [3:0]  protect;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    swp_sequencer uut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_blk(wr_blk),
        .wr_addr(wr_addr), .wr_data(wr_data), .period_end(period_end),
        .dec_valid(dec_valid), .dec_kind(dec_kind), .dummy_busy(dummy_busy),
        .protect(protect)
    );

    task automatic check_out(vec_t v);
        logic       ev = (v.ek != KN);
        logic       ed = (v.ek == KD);
        logic [1:0] ek = ev ? v.ek : KP;
        checks++;
        if (dec_valid !== ev || dec_kind !== ek || dummy_busy !== ed || protect !== v.ep) begin
            errors++;
            $display("FAIL R%0d: valid=%b kind=%0d dummy=%b prot=%b expected valid=%b kind=%0d dummy=%b prot=%b",
                     v.req, dec_valid, dec_kind, dummy_busy, protect, ev, ek, ed, v.ep);
        end
    endtask

    task automatic run_vec(vec_t v);
        @(negedge clk);
        wr_valid = v.wv; period_end = v.pe; wr_blk = v.blk;
        wr_addr = v.addr; wr_data = v.data;
        @(posedge clk);
        #1;
        check_out(v);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state and power-up flags
        check_out(mk(0,0,0,17'h0,8'h0,KN,4'b0000,1));
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check_out(mk(0,0,0,17'h0,8'h0,KN,4'b0000,13));   // R13 idle without writes

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R1: reset mid-prefix keeps flags, drops the prefix
        run_vec(mk(1,0,2,A5,8'hAA,KC,4'b0100,1));
        @(negedge clk);
        wr_valid = 1'b0; period_end = 1'b0; rst = 1'b1;
        @(posedge clk);
        #1;
        check_out(mk(0,0,0,17'h0,8'h0,KN,4'b0100,1));
        @(negedge clk);
        rst = 1'b0;
        run_vec(mk(1,0,2,A2,8'h55,KD,4'b0100,1));
        run_vec(mk(0,0,0,17'h0,8'h0,KN,4'b0100,13));     // R13

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2: watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule